// File: doc/BRIEF.md
# Checkpointed Register Alias Table

This block is the rename map of an out-of-order core. For every architectural register it holds either a pointer to the architectural register file or the physical tag of the youngest in-flight producer. Each renamed instruction reads its two source mappings in the same cycle. At the next clock edge its destination is bound to the newly allocated physical tag.

Whenever a branch is renamed, the block copies the whole map, including that cycle's destination write, into a shadow slot taken from a small pool. If the branch later resolves as mispredicted, the live map is reloaded from that slot in one cycle. The slot and every slot allocated after it go back to the pool, and renaming resumes on the following cycle. A correctly predicted branch returns only its own slot. When no slot is usable, the fallback is a commit-time reset. Software or the core stalls rename until older work has drained, then pulses the reset, which points every entry back at the architectural register file and empties the pool.

Top module: `ckpt_rat`

## Requirements
- R1: After reset every entry reads as architectural (prf flag 0, tag 0), all checkpoint slots are free, and stall_o is low.
- R2: Source mappings are read combinationally from the live map as it stands before the current instruction. A fired rename with dst_we_i set binds dst_i to {prf=1, new_tag_i} from the next cycle.
- R3: A fired branch rename takes the lowest-numbered free slot and shows its number on ckpt_id_o in the same cycle. The slot stores the map including that instruction's destination write.
- R4: A branch rename while all slots are busy raises stall_o and changes neither the map nor the pool.
- R5: A mispredicted resolve makes the live map, from the next cycle, equal to the snapshot stored for that slot.
- R6: A mispredicted resolve frees its own slot and every slot allocated after it. Slots allocated earlier stay busy.
- R7: A correctly predicted resolve frees only its own slot.
- R8: In a cycle with a mispredicted resolve, any rename request is stalled and writes nothing.
- R9: arch_reset_i stalls rename in that cycle. From the next cycle all entries read as architectural and all slots are free, and resolves in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ren_valid_i | input | 1 | Rename request |
| ren_branch_i | input | 1 | Request is a branch needing a checkpoint |
| src1_i | input | AW | First source architectural register |
| src2_i | input | AW | Second source architectural register |
| dst_i | input | AW | Destination architectural register |
| dst_we_i | input | 1 | Instruction writes dst_i |
| new_tag_i | input | PTAG_W | Physical tag allocated for the destination |
| src1_prf_o | output | 1 | First source is in flight (1) or architectural (0) |
| src1_tag_o | output | PTAG_W | First source physical tag |
| src2_prf_o | output | 1 | Second source is in flight |
| src2_tag_o | output | PTAG_W | Second source physical tag |
| ckpt_id_o | output | CW | Slot given to the branch in this cycle |
| stall_o | output | 1 | Rename request not accepted this cycle |
| resolve_valid_i | input | 1 | A branch resolves |
| resolve_id_i | input | CW | Slot of the resolving branch |
| resolve_mispred_i | input | 1 | The resolving branch was mispredicted |
| arch_reset_i | input | 1 | Commit-time reset of all mappings to the register file |

## Verification
A stale or corrupted map entry shows up on the source tag outputs in the first cycle that any instruction reads that register. A missed restore therefore appears one cycle after the mispredicted resolve. Errors in the pool's age order do not reach the ports right away. They surface later as a wrong ckpt_id_o on the next branch, or as a stall_o that rises too early or too late once the pool is nearly full. For that reason the bench keeps the pool busy and mixes resolves of old and young slots.

// File: rtl/ckpt_rat_pkg.sv
package ckpt_rat_pkg;
  typedef enum logic [1:0] {
    MAP_HOLD    = 2'd0,
    MAP_WRITE   = 2'd1,
    MAP_RESTORE = 2'd2,
    MAP_CLEAR   = 2'd3
  } map_op_e;
endpackage

// File: rtl/rat_map.sv
module rat_map import ckpt_rat_pkg::*; #(
  parameter int NUM_ARCH = 16,
  parameter int PTAG_W   = 6,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int ENT_W   = PTAG_W + 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  map_op_e                           op_i,
  input  logic [AW-1:0]                     dst_i,
  input  logic [PTAG_W-1:0]                 tag_i,
  input  logic [NUM_ARCH-1:0][ENT_W-1:0]    restore_i,
  output logic [NUM_ARCH-1:0][ENT_W-1:0]    map_o,
  output logic [NUM_ARCH-1:0][ENT_W-1:0]    map_nxt_o
);
  logic [NUM_ARCH-1:0][ENT_W-1:0] map_q;

  always_comb begin
    map_nxt_o = map_q;
    unique case (op_i)
      MAP_WRITE:   map_nxt_o[dst_i] = {1'b1, tag_i};
      MAP_RESTORE: map_nxt_o = restore_i;
      MAP_CLEAR:   map_nxt_o = '0;
      default:     ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) map_q <= '0;
    else         map_q <= map_nxt_o;
  end

  assign map_o = map_q;

  a_r2_write_binds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == MAP_WRITE |=> map_q[$past(dst_i)] == {1'b1, $past(tag_i)});
  a_r5_restore_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == MAP_RESTORE |=> map_q == $past(restore_i));
  a_r9_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == MAP_CLEAR |=> map_q == '0);
endmodule

// File: rtl/ckpt_store.sv
module ckpt_store #(
  parameter int NUM_ARCH = 16,
  parameter int ENT_W    = 7,
  parameter int NUM_CKPT = 4,
  localparam int CW      = $clog2(NUM_CKPT)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [CW-1:0]                     wr_id_i,
  input  logic [NUM_ARCH-1:0][ENT_W-1:0]    wr_map_i,
  input  logic [CW-1:0]                     rd_id_i,
  output logic [NUM_ARCH-1:0][ENT_W-1:0]    rd_map_o
);
  logic [NUM_CKPT-1:0][NUM_ARCH-1:0][ENT_W-1:0] slot_q;

  for (genvar s = 0; s < NUM_CKPT; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  slot_q[s] <= '0;
      else if (wr_en_i && wr_id_i == CW'(s))        slot_q[s] <= wr_map_i;
    end
  end

  assign rd_map_o = slot_q[rd_id_i];
endmodule

// File: rtl/ckpt_pool.sv
module ckpt_pool #(
  parameter int NUM_CKPT = 4,
  localparam int CW      = $clog2(NUM_CKPT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          alloc_i,
  output logic [CW-1:0] alloc_id_o,
  output logic          full_o,
  input  logic          resolve_i,
  input  logic          mispred_i,
  input  logic [CW-1:0] resolve_id_i
);
  logic [NUM_CKPT-1:0]               busy_q;
  // older_q[r][c]: slot c was allocated before slot r
  logic [NUM_CKPT-1:0][NUM_CKPT-1:0] older_q;
  logic [NUM_CKPT-1:0]               free_mask, younger;

  always_comb begin
    alloc_id_o = '0;
    for (int i = NUM_CKPT - 1; i >= 0; i--)
      if (!busy_q[i]) alloc_id_o = CW'(i);
  end
  assign full_o = &busy_q;

  always_comb begin
    for (int k = 0; k < NUM_CKPT; k++)
      younger[k] = busy_q[k] & older_q[k][resolve_id_i];
    free_mask = '0;
    if (resolve_i) begin
      free_mask[resolve_id_i] = 1'b1;
      if (mispred_i) free_mask = free_mask | younger;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= '0;
      older_q <= '0;
    end else if (clear_i) begin
      busy_q  <= '0;
      older_q <= '0;
    end else begin
      busy_q <= (busy_q & ~free_mask) |
                (alloc_i ? (NUM_CKPT'(1) << alloc_id_o) : '0);
      for (int r = 0; r < NUM_CKPT; r++) begin
        if (alloc_i && alloc_id_o == CW'(r)) older_q[r] <= busy_q & ~free_mask;
        else                                  older_q[r] <= older_q[r] & ~free_mask;
      end
    end
  end

  a_r3_alloc_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i && !clear_i |=> busy_q[$past(alloc_id_o)]);
  a_r3_no_alloc_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
  a_r6_own_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_i && mispred_i && !clear_i |=> !busy_q[$past(resolve_id_i)]);
  a_r7_one_freed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolve_i && !mispred_i && !alloc_i && !clear_i && busy_q[resolve_id_i]
    |=> $countones(busy_q) + 1 == $countones($past(busy_q)));
  a_r9_pool_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> busy_q == '0);
endmodule

// File: rtl/ckpt_rat.sv
module ckpt_rat import ckpt_rat_pkg::*; #(
  parameter int NUM_ARCH = 16,
  parameter int PTAG_W   = 6,
  parameter int NUM_CKPT = 4,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int CW      = $clog2(NUM_CKPT),
  localparam int ENT_W   = PTAG_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_valid_i,
  input  logic              ren_branch_i,
  input  logic [AW-1:0]     src1_i,
  input  logic [AW-1:0]     src2_i,
  input  logic [AW-1:0]     dst_i,
  input  logic              dst_we_i,
  input  logic [PTAG_W-1:0] new_tag_i,
  output logic              src1_prf_o,
  output logic [PTAG_W-1:0] src1_tag_o,
  output logic              src2_prf_o,
  output logic [PTAG_W-1:0] src2_tag_o,
  output logic [CW-1:0]     ckpt_id_o,
  output logic              stall_o,
  input  logic              resolve_valid_i,
  input  logic [CW-1:0]     resolve_id_i,
  input  logic              resolve_mispred_i,
  input  logic              arch_reset_i
);
  logic [NUM_ARCH-1:0][ENT_W-1:0] map, map_nxt, snap;
  logic    recover, pool_full, fire, alloc;
  map_op_e op;

  assign recover = resolve_valid_i & resolve_mispred_i;
  assign stall_o = ren_valid_i & (arch_reset_i | recover | (ren_branch_i & pool_full));
  assign fire    = ren_valid_i & ~stall_o;
  assign alloc   = fire & ren_branch_i;

  always_comb begin
    if (arch_reset_i)          op = MAP_CLEAR;
    else if (recover)          op = MAP_RESTORE;
    else if (fire && dst_we_i) op = MAP_WRITE;
    else                       op = MAP_HOLD;
  end

  rat_map #(.NUM_ARCH(NUM_ARCH), .PTAG_W(PTAG_W)) i_map (
    .clk_i, .rst_ni, .op_i(op), .dst_i, .tag_i(new_tag_i),
    .restore_i(snap), .map_o(map), .map_nxt_o(map_nxt)
  );

  ckpt_store #(.NUM_ARCH(NUM_ARCH), .ENT_W(ENT_W), .NUM_CKPT(NUM_CKPT)) i_store (
    .clk_i, .rst_ni, .wr_en_i(alloc), .wr_id_i(ckpt_id_o), .wr_map_i(map_nxt),
    .rd_id_i(resolve_id_i), .rd_map_o(snap)
  );

  ckpt_pool #(.NUM_CKPT(NUM_CKPT)) i_pool (
    .clk_i, .rst_ni, .clear_i(arch_reset_i), .alloc_i(alloc),
    .alloc_id_o(ckpt_id_o), .full_o(pool_full),
    .resolve_i(resolve_valid_i & ~arch_reset_i), .mispred_i(resolve_mispred_i),
    .resolve_id_i
  );

  assign {src1_prf_o, src1_tag_o} = map[src1_i];
  assign {src2_prf_o, src2_tag_o} = map[src2_i];

  a_r4_stall_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_valid_i && ren_branch_i && pool_full |-> stall_o);
  a_r4_map_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_valid_i && ren_branch_i && pool_full && !resolve_valid_i && !arch_reset_i
    |=> map == $past(map));
  a_r8_recover_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ren_valid_i && recover |-> stall_o);
endmodule

// File: tb/test_ckpt_rat.sv
`timescale 1ns/1ps
module test_ckpt_rat;
  localparam int NA = 16, PW = 6, NC = 4;
  localparam int AW = $clog2(NA), CW = $clog2(NC);

  logic clk = 0, rst_n = 0;
  logic ren_v, ren_br, dst_we, rv, rmis, ar;
  logic [AW-1:0] s1, s2, dst;
  logic [PW-1:0] tag;
  logic [CW-1:0] rid;
  logic s1p, s2p, stall;
  logic [PW-1:0] s1t, s2t;
  logic [CW-1:0] cid;

  always #2.5 clk = ~clk;

  ckpt_rat #(.NUM_ARCH(NA), .PTAG_W(PW), .NUM_CKPT(NC)) i_ckpt_rat (
    .clk_i(clk), .rst_ni(rst_n), .ren_valid_i(ren_v), .ren_branch_i(ren_br),
    .src1_i(s1), .src2_i(s2), .dst_i(dst), .dst_we_i(dst_we), .new_tag_i(tag),
    .src1_prf_o(s1p), .src1_tag_o(s1t), .src2_prf_o(s2p), .src2_tag_o(s2t),
    .ckpt_id_o(cid), .stall_o(stall), .resolve_valid_i(rv), .resolve_id_i(rid),
    .resolve_mispred_i(rmis), .arch_reset_i(ar));

  int n_chk = 0, n_fail = 0;
  // reference model: entry value = prf*64 + tag
  int m_map[NA];
  int m_snap[NC][NA];
  bit m_busy[NC];
  int m_seq[NC];
  int seq_ctr = 0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NC; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic int n_busy();
    int c = 0;
    for (int i = 0; i < NC; i++) c += m_busy[i];
    return c;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NA; i++) m_map[i] = 0;
    for (int i = 0; i < NC; i++) m_busy[i] = 0;
  endtask

  // one cycle: drive at negedge, check comb outputs, update model, wait edge
  task automatic step(bit v, bit br, int a1, int a2, int d, bit we, int t,
                      bit r, int ri, bit mis, bit rst_arch);
    bit exp_stall, fire; int fid;
    @(negedge clk);
    ren_v = v; ren_br = br; s1 = AW'(a1); s2 = AW'(a2); dst = AW'(d);
    dst_we = we; tag = PW'(t); rv = r; rid = CW'(ri); rmis = mis; ar = rst_arch;
    #1;
    exp_stall = v && (rst_arch || (r && mis) || (br && n_busy() == NC));
    fire = v && !exp_stall;
    check("R8/R4/R9 stall", int'(stall), int'(exp_stall));
    check("R2 src1", int'({s1p, s1t}), m_map[a1]);
    check("R2 src2", int'({s2p, s2t}), m_map[a2]);
    fid = lowest_free();
    if (fire && br) check("R3 ckpt id", int'(cid), fid);
    if (rst_arch) model_reset();
    else if (r && mis) begin
      int base = m_seq[ri];
      for (int i = 0; i < NA; i++) m_map[i] = m_snap[ri][i];
      for (int k = 0; k < NC; k++)
        if (m_busy[k] && (k == ri || m_seq[k] > base)) m_busy[k] = 0;
    end else begin
      if (fire && we) m_map[d] = 64 + t;
      if (fire && br) begin
        m_busy[fid] = 1; m_seq[fid] = seq_ctr++;
        for (int i = 0; i < NA; i++) m_snap[fid][i] = m_map[i];
      end
      if (r) m_busy[ri] = 0;
    end
    @(posedge clk);
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,0,0,0,0); endtask

  function automatic int pick_busy();
    int c = n_busy(), k;
    if (c == 0) return -1;
    k = $urandom_range(c - 1);
    for (int i = 0; i < NC; i++) if (m_busy[i]) begin
      if (k == 0) return i;
      k--;
    end
    return -1;
  endfunction

  initial begin
    #50000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int sd; bit r_v, r_m; int r_i;
    ren_v = 0; ren_br = 0; s1 = 0; s2 = 0; dst = 0; dst_we = 0; tag = 0;
    rv = 0; rid = 0; rmis = 0; ar = 0;
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 stall", int'(stall), 0);
    for (int a = 0; a < NA; a += 5) begin
      s1 = AW'(a); #0.1;
      check("R1 arch entry", int'({s1p, s1t}), 0);
    end
    // R2 directed: write r3, read back next cycle
    step(1,0,3,3,3,1,17,0,0,0,0);
    step(1,0,3,4,5,0,0,0,0,0,0);
    // R3/R4: fill all slots, then a fifth branch stalls
    for (int b = 0; b < NC; b++) step(1,1,0,0,b+1,1,20+b,0,0,0,0);
    step(1,1,0,0,9,1,40,0,0,0,0);
    step(1,0,9,9,0,0,0,0,0,0,0);  // r4_ map unchanged check via src
    // R6: mispredict slot 1 frees 1,2,3; next branch gets 1
    step(0,0,0,0,0,0,0,1,1,1,0);
    step(1,0,1,2,0,0,0,0,0,0,0);  // R5 restored map reads
    step(1,0,3,4,0,0,0,0,0,0,0);
    step(1,1,0,0,0,0,0,0,0,0,0);
    // R7: correct resolve of slot 0 frees only 0
    step(0,0,0,0,0,0,0,1,0,0,0);
    step(1,1,0,0,0,0,0,0,0,0,0);
    step(1,1,0,0,0,0,0,0,0,0,0);
    // R8: rename with dst during mispredict is blocked
    step(1,0,0,0,7,1,55,1,2,1,0);
    step(1,0,7,7,0,0,0,0,0,0,0);
    // R9: arch reset clears map and pool
    step(1,1,0,0,6,1,33,1,0,1,1);
    step(1,0,3,7,0,0,0,0,0,0,0);
    step(1,1,0,0,0,0,0,0,0,0,0);
    // random mix
    sd = $urandom(1234);
    for (int c = 0; c < 4000; c++) begin
      r_i = pick_busy();
      r_v = (r_i >= 0) && ($urandom_range(3) == 0);
      r_m = $urandom_range(2) == 0;
      step($urandom_range(3) != 0, $urandom_range(2) == 0,
           $urandom_range(NA-1), $urandom_range(NA-1), $urandom_range(NA-1),
           $urandom_range(1), $urandom_range(63),
           r_v, r_v ? r_i : 0, r_m, $urandom_range(199) == 0);
    end
    idle();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule